// File: doc/BRIEF.md
# Per-Channel Gamma Lookup Table with Indirect Loading Port

This block applies gamma correction to a stream of 8-bit RGB pixels. Each colour channel has its own 256-entry table of 10-bit values. While correction is off, each channel passes through widened to 10 bits with two zero bits appended. While correction is on, each incoming channel value picks its output from its own table.

Software reaches the tables only through three registers on a small register bus: a control/status word, an address word and a data word. First it turns correction off and waits for the address-ready flag. Then it writes an address word that selects one or more channels, a starting entry and optional auto-increment. After that it streams entry values through the data register. An address word can also carry a read request. The entry at that address is then fetched, read-ready rises, and each read of the data register returns the fetched value and prefetches the next entry. Correction is turned back on once all channels are loaded. While it is on, the table access paths are closed.

Top module: `gamma_lut_port`

## Requirements
- R1: After reset the control word reads 0x30 (enable 0, write-ready and address-ready 1), the address word reads 0 and no pixel is marked valid.
- R2: With enable (control bit 0) clear, each output channel equals its input channel shifted left by two. It is marked valid exactly two clock edges after the input was accepted.
- R3: With enable set, each output channel equals its own table's entry at the input channel value, with the same two-edge latency.
- R4: Control bits 4 (write-ready) and 5 (address-ready) read 1 when enable is clear and 0 when it is set. Writes to bits 3 to 5 have no effect.
- R5: While enable is set, writes to the address and data registers are ignored. Tables, pointer, channel selection and read state keep their values.
- R6: A data-register write stores its low 10 bits into every selected channel at the current pointer. With auto-increment (address bit 11) set, the pointer then advances by one and wraps from 255 to 0. The same advance applies to each fetch.
- R7: With auto-increment clear, data writes and fetches leave the pointer unchanged.
- R8: Address bits 8, 9 and 10 select blue, green and red. Any combination may be set, and a data write updates every selected channel at the same entry and leaves the others untouched.
- R9: An address write with bit 12 set and at least one channel selected fetches that entry, and read-ready (control bit 3) reads 1 from the next cycle on. Each data-register read returns the fetched entry and prefetches the next one. If several channels are selected, red takes priority over green, and green over blue. Bit 12 always reads back as 0.
- R10: Control bits 1, 2, 6 and 7 are stored and read back unchanged, and they do not affect the pixel path.
- R11: Bus read data is valid in the cycle after the read strobe and is 0 in any cycle that follows no read.
- R12: Read-ready clears on an address write without a read request, and when enable is written as 1. The data register reads 0 while read-ready is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select: 0 control, 1 data, 2 address |
| bus_wdata | input | 13 | Register write data |
| bus_rdata | output | 13 | Register read data, one cycle after the strobe |
| pix_valid | input | 1 | Input pixel valid |
| pix_r | input | 8 | Input red |
| pix_g | input | 8 | Input green |
| pix_b | input | 8 | Input blue |
| out_valid | output | 1 | Output pixel valid |
| out_r | output | 10 | Output red |
| out_g | output | 10 | Output green |
| out_b | output | 10 | Output blue |

## Verification
A pixel accepted at one clock edge shows up at the output after the second edge. Bus read data and read-ready appear after the first edge that follows the strobe or the read request. The bench model advances on every rising edge with the same register counts, and every output is compared on the falling edge that follows, so each result is sampled in the first cycle it is due. Values that must be left untouched are observed after the ignored stimulus: by read-back through the indirect port and by pixels sent through the enabled table.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;
  localparam int NUM_CH = 3;
  localparam int CH_B   = 0;
  localparam int CH_G   = 1;
  localparam int CH_R   = 2;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_DATA = 2'd1;
  localparam logic [1:0] REG_ADDR = 2'd2;

  localparam int CB_EN     = 0;
  localparam int CB_SET    = 1;
  localparam int CB_XFER   = 2;
  localparam int CB_RDRDY  = 3;
  localparam int CB_WRRDY  = 4;
  localparam int CB_ADRRDY = 5;
  localparam int CB_REV    = 6;
  localparam int CB_VCOM   = 7;

  typedef struct packed {
    logic vcom;
    logic rev;
    logic xfer;
    logic set;
    logic en;
  } ctl_t;
endpackage

// File: rtl/gamma_table.sv
module gamma_table #(
  parameter int IDX_W = 8,
  parameter int ENT_W = 10
) (
  input  logic             clk,
  input  logic             we,
  input  logic             re,
  input  logic [IDX_W-1:0] addr,
  input  logic [ENT_W-1:0] wdata,
  output logic [ENT_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [ENT_W-1:0] mem [DEPTH];

  // single port, read-first; block RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/gamma_regs.sv
module gamma_regs
  import gamma_lut_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int ENT_W = 10,
  parameter int BUS_W = 13
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         bus_wr,
  input  logic                         bus_rd,
  input  logic [1:0]                   bus_addr,
  input  logic [BUS_W-1:0]             bus_wdata,
  output logic [BUS_W-1:0]             bus_rdata,
  input  logic [NUM_CH-1:0][ENT_W-1:0] tbl_q,
  output logic                         en,
  output logic [NUM_CH-1:0]            host_we,
  output logic                         host_re,
  output logic [PIX_W-1:0]             host_addr,
  output logic [ENT_W-1:0]             host_wdata
);
  localparam int SEL_LSB  = PIX_W;
  localparam int AINC_BIT = PIX_W + NUM_CH;
  localparam int RDQ_BIT  = PIX_W + NUM_CH + 1;

  ctl_t              ctl;
  logic              rd_rdy;
  logic [PIX_W-1:0]  ptr;
  logic [NUM_CH-1:0] sel;
  logic              ainc;

  logic              host_ok;
  logic              ctl_wr, addr_wr, data_wr, data_rd;
  logic              fetch_a, fetch_d;
  logic [NUM_CH-1:0] w_sel;
  logic              w_ainc, w_req;
  logic [ENT_W-1:0]  picked;
  logic [BUS_W-1:0]  ctl_word, addr_word, data_word, rd_word;
  logic [PIX_W-1:0]  ptr_load;

  assign en      = ctl.en;
  assign host_ok = ~ctl.en;
  assign ctl_wr  = bus_wr && (bus_addr == REG_CTRL);
  assign addr_wr = bus_wr && (bus_addr == REG_ADDR) && host_ok;
  assign data_wr = bus_wr && (bus_addr == REG_DATA) && host_ok;
  assign data_rd = bus_rd && (bus_addr == REG_DATA);

  assign w_sel   = bus_wdata[SEL_LSB +: NUM_CH];
  assign w_ainc  = bus_wdata[AINC_BIT];
  assign w_req   = bus_wdata[RDQ_BIT] && (|w_sel);

  assign fetch_a = addr_wr && w_req;
  assign fetch_d = data_rd && rd_rdy && host_ok;

  assign host_re    = fetch_a || fetch_d;
  assign host_addr  = fetch_a ? bus_wdata[PIX_W-1:0] : ptr;
  assign host_we    = data_wr ? sel : '0;
  assign host_wdata = bus_wdata[ENT_W-1:0];

  assign ptr_load = bus_wdata[PIX_W-1:0] + {{(PIX_W-1){1'b0}}, (fetch_a && w_ainc)};

  // read priority: highest channel index (red) wins
  always_comb begin
    picked = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (sel[c]) picked = tbl_q[c];
    end
  end

  always_comb begin
    ctl_word            = '0;
    ctl_word[CB_EN]     = ctl.en;
    ctl_word[CB_SET]    = ctl.set;
    ctl_word[CB_XFER]   = ctl.xfer;
    ctl_word[CB_RDRDY]  = rd_rdy;
    ctl_word[CB_WRRDY]  = host_ok;
    ctl_word[CB_ADRRDY] = host_ok;
    ctl_word[CB_REV]    = ctl.rev;
    ctl_word[CB_VCOM]   = ctl.vcom;

    addr_word                      = '0;
    addr_word[PIX_W-1:0]           = ptr;
    addr_word[SEL_LSB +: NUM_CH]   = sel;
    addr_word[AINC_BIT]            = ainc;

    data_word             = '0;
    data_word[ENT_W-1:0]  = (rd_rdy && host_ok) ? picked : '0;

    case (bus_addr)
      REG_CTRL: rd_word = ctl_word;
      REG_DATA: rd_word = data_word;
      REG_ADDR: rd_word = addr_word;
      default:  rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl       <= '0;
      rd_rdy    <= 1'b0;
      ptr       <= '0;
      sel       <= '0;
      ainc      <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (ctl_wr) begin
        ctl.en   <= bus_wdata[CB_EN];
        ctl.set  <= bus_wdata[CB_SET];
        ctl.xfer <= bus_wdata[CB_XFER];
        ctl.rev  <= bus_wdata[CB_REV];
        ctl.vcom <= bus_wdata[CB_VCOM];
      end

      if (addr_wr) begin
        sel  <= w_sel;
        ainc <= w_ainc;
        ptr  <= ptr_load;
      end else if ((data_wr || fetch_d) && ainc) begin
        ptr <= ptr + 1'b1;
      end

      if (ctl_wr && bus_wdata[CB_EN]) rd_rdy <= 1'b0;
      else if (addr_wr)               rd_rdy <= fetch_a;

      bus_rdata <= bus_rd ? rd_word : '0;
    end
  end

  // R5
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.en |=> ($stable(ptr) && $stable(sel) && $stable(ainc)));

  // R6
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (data_wr && ainc) |=> (ptr == PIX_W'($past(ptr) + 1'b1)));

  // R9
  rdrdy_set_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_a |=> rd_rdy);

  // R12
  rdrdy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && bus_wdata[CB_EN]) |=> !rd_rdy);

  // R11
  rdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));
endmodule

// File: rtl/gamma_pixpath.sv
module gamma_pixpath
  import gamma_lut_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int ENT_W = 10
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         en,
  input  logic                         pix_valid,
  input  logic [NUM_CH-1:0][PIX_W-1:0] pix_c,
  input  logic [NUM_CH-1:0][ENT_W-1:0] tbl_q,
  output logic                         out_valid,
  output logic [NUM_CH-1:0][ENT_W-1:0] out_c
);
  localparam int PAD = ENT_W - PIX_W;

  logic                         v1, en1;
  logic [NUM_CH-1:0][ENT_W-1:0] byp1;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1        <= 1'b0;
      en1       <= 1'b0;
      byp1      <= '0;
      out_valid <= 1'b0;
      out_c     <= '0;
    end else begin
      v1        <= pix_valid;
      en1       <= en;
      out_valid <= v1;
      for (int c = 0; c < NUM_CH; c++) begin
        byp1[c]  <= {pix_c[c], {PAD{1'b0}}};
        out_c[c] <= en1 ? tbl_q[c] : byp1[c];
      end
    end
  end

  // R2
  lat_chk: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> ##2 out_valid);

  // R2
  bypass_red_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && !en) |-> ##2 (out_c[CH_R] == {$past(pix_c[CH_R], 2), {PAD{1'b0}}}));
endmodule

// File: rtl/gamma_lut_port.sv
module gamma_lut_port
  import gamma_lut_pkg::*;
#(
  parameter  int PIX_W = 8,
  parameter  int ENT_W = 10,
  localparam int BUS_W = PIX_W + NUM_CH + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_r,
  input  logic [PIX_W-1:0] pix_g,
  input  logic [PIX_W-1:0] pix_b,
  output logic             out_valid,
  output logic [ENT_W-1:0] out_r,
  output logic [ENT_W-1:0] out_g,
  output logic [ENT_W-1:0] out_b
);
  logic                         en;
  logic [NUM_CH-1:0]            host_we;
  logic                         host_re;
  logic [PIX_W-1:0]             host_addr;
  logic [ENT_W-1:0]             host_wdata;
  logic [NUM_CH-1:0][ENT_W-1:0] tbl_q;
  logic [NUM_CH-1:0][PIX_W-1:0] pix_c;
  logic [NUM_CH-1:0][ENT_W-1:0] out_c;

  assign pix_c = {pix_r, pix_g, pix_b};
  assign out_r = out_c[CH_R];
  assign out_g = out_c[CH_G];
  assign out_b = out_c[CH_B];

  gamma_regs #(.PIX_W(PIX_W), .ENT_W(ENT_W), .BUS_W(BUS_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .tbl_q      (tbl_q),
    .en         (en),
    .host_we    (host_we),
    .host_re    (host_re),
    .host_addr  (host_addr),
    .host_wdata (host_wdata)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    gamma_table #(.IDX_W(PIX_W), .ENT_W(ENT_W)) u_tbl (
      .clk   (clk),
      .we    (host_we[c]),
      .re    (host_re || en),
      .addr  (en ? pix_c[c] : host_addr),
      .wdata (host_wdata),
      .rdata (tbl_q[c])
    );
  end

  gamma_pixpath #(.PIX_W(PIX_W), .ENT_W(ENT_W)) u_pix (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .pix_valid (pix_valid),
    .pix_c     (pix_c),
    .tbl_q     (tbl_q),
    .out_valid (out_valid),
    .out_c     (out_c)
  );

  // R5
  no_write_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    en |-> (host_we == '0));
endmodule

// File: tb/tb_gamma_lut_port.sv
module tb_gamma_lut_port;
  localparam int DEPTH = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [12:0] bus_wdata = '0;
  logic [12:0] bus_rdata;
  logic        pix_valid = 1'b0;
  logic [7:0]  pix_r = '0, pix_g = '0, pix_b = '0;
  logic        out_valid;
  logic [9:0]  out_r, out_g, out_b;

  always #2 clk = ~clk;

  gamma_lut_port dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pix_valid(pix_valid),
    .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b), .out_valid(out_valid),
    .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  int    n_tests = 0, n_fail = 0;
  bit    done = 0;
  string cur_tag = "R11";

  task automatic check_eq(string tag, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: %s got %0h exp %0h", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int    tbl [3][DEPTH];
  int    m_q [3];
  bit    m_en, m_set, m_xfer, m_rev, m_vcom, m_rdrdy, m_ainc;
  int    m_ptr;
  bit [2:0] m_sel;
  bit    s1_v, s1_en, e_v, e_en;
  int    s1_d [3];
  int    e_d [3];
  int    e_rdata;
  string e_tag = "R11";
  bit    en_old;
  int    pin [3];

  function automatic int pick_q();
    if (m_sel[2]) return m_q[2];
    if (m_sel[1]) return m_q[1];
    if (m_sel[0]) return m_q[0];
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_set = 0; m_xfer = 0; m_rev = 0; m_vcom = 0;
      m_rdrdy = 0; m_ainc = 0; m_ptr = 0; m_sel = 0;
      s1_v = 0; e_v = 0; e_rdata = 0; e_tag = "R1";
    end else begin
      en_old = m_en;
      e_v = s1_v; e_en = s1_en;
      for (int c = 0; c < 3; c++) e_d[c] = s1_d[c];
      pin[2] = int'(pix_r); pin[1] = int'(pix_g); pin[0] = int'(pix_b);
      s1_v = pix_valid; s1_en = m_en;
      for (int c = 0; c < 3; c++) s1_d[c] = m_en ? tbl[c][pin[c]] : pin[c] * 4;

      e_rdata = 0; e_tag = "R11";
      if (bus_rd) begin
        e_tag = cur_tag;
        case (bus_addr)
          2'd0: e_rdata = int'(m_vcom) * 128 + int'(m_rev) * 64 + int'(!m_en) * 48 +
                          int'(m_rdrdy) * 8 + int'(m_xfer) * 4 + int'(m_set) * 2 + int'(m_en);
          2'd1: e_rdata = m_rdrdy ? pick_q() : 0;
          2'd2: e_rdata = int'(m_ainc) * 2048 + int'(m_sel) * 256 + m_ptr;
          default: e_rdata = 0;
        endcase
      end

      if (bus_wr && bus_addr == 2'd0) begin
        m_en = bus_wdata[0]; m_set = bus_wdata[1]; m_xfer = bus_wdata[2];
        m_rev = bus_wdata[6]; m_vcom = bus_wdata[7];
        if (bus_wdata[0]) m_rdrdy = 0;
      end
      if (bus_wr && bus_addr == 2'd2 && !en_old) begin
        m_sel = bus_wdata[10:8]; m_ainc = bus_wdata[11]; m_ptr = int'(bus_wdata[7:0]);
        if (bus_wdata[12] && m_sel != 0) begin
          for (int c = 0; c < 3; c++) m_q[c] = tbl[c][m_ptr];
          m_rdrdy = 1;
          if (m_ainc) m_ptr = (m_ptr + 1) % DEPTH;
        end else m_rdrdy = 0;
      end
      if (bus_wr && bus_addr == 2'd1 && !en_old) begin
        for (int c = 0; c < 3; c++) if (m_sel[c]) tbl[c][m_ptr] = int'(bus_wdata[9:0]);
        if (m_ainc) m_ptr = (m_ptr + 1) % DEPTH;
      end
      if (bus_rd && bus_addr == 2'd1 && m_rdrdy && !en_old) begin
        for (int c = 0; c < 3; c++) m_q[c] = tbl[c][m_ptr];
        if (m_ainc) m_ptr = (m_ptr + 1) % DEPTH;
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check_eq(e_v ? (e_en ? "R3" : "R2") : "R1", "out_valid", int'(out_valid), int'(e_v));
      if (e_v) begin
        check_eq(e_en ? "R3" : "R2", "out_r", int'(out_r), e_d[2]);
        check_eq(e_en ? "R3" : "R2", "out_g", int'(out_g), e_d[1]);
        check_eq(e_en ? "R3" : "R2", "out_b", int'(out_b), e_d[0]);
      end
      check_eq(e_tag, "bus_rdata", int'(bus_rdata), e_rdata);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic bus_w(input int a, input int d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 2'(a); bus_wdata = 13'(d);
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_r(input int a, output int v);
    @(negedge clk); bus_rd = 1'b1; bus_addr = 2'(a);
    @(negedge clk); bus_rd = 1'b0; v = int'(bus_rdata);
  endtask

  task automatic expect_r(input int a, input int exp, input string tag);
    int v;
    cur_tag = tag;
    bus_r(a, v);
    check_eq(tag, "register read", v, exp);
    cur_tag = "R11";
  endtask

  task automatic pixels(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pix_valid = 1'b1;
      pix_r = 8'((seed + i * 37) & 255);
      pix_g = 8'((seed * 3 + i * 11) & 255);
      pix_b = 8'((255 - i * 5 - seed) & 255);
    end
    @(negedge clk); pix_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic one_pix(input int r, input int g, input int b,
                         input int er, input int eg, input int eb, input string tag);
    @(negedge clk); pix_valid = 1'b1; pix_r = 8'(r); pix_g = 8'(g); pix_b = 8'(b);
    @(negedge clk); pix_valid = 1'b0;
    @(negedge clk);
    check_eq(tag, "direct out_valid", int'(out_valid), 1);
    check_eq(tag, "direct out_r", int'(out_r), er);
    check_eq(tag, "direct out_g", int'(out_g), eg);
    check_eq(tag, "direct out_b", int'(out_b), eb);
  endtask

  function automatic int curve(input int c, input int i);
    if (c == 2) return i * 4;
    if (c == 1) return 1023 - i * 4;
    return (i * 7 + 3) & 1023;
  endfunction

  task automatic load_channel(input int c);
    int v;
    cur_tag = "R4";
    bus_r(0, v);
    check_eq("R4", "address-ready before load", (v >> 5) & 1, 1);
    cur_tag = "R11";
    bus_w(2, (1 << 11) | (1 << (8 + c)));
    for (int i = 0; i < DEPTH; i++) bus_w(1, curve(c, i));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1
    check_eq("R1", "out_valid after reset", int'(out_valid), 0);
    expect_r(0, 'h30, "R1");
    expect_r(2, 0, "R1");
    // R2 bypass
    pixels(20, 0);
    one_pix('hFF, 'h01, 'h80, 'h3FC, 'h004, 'h200, "R2");
    // load tables
    load_channel(2); load_channel(1); load_channel(0);
    // R8 multi-select write
    bus_w(2, 'h0300 | 'h10);
    bus_w(1, 'h155);
    bus_w(2, (1 << 12) | (1 << 9) | 'h10);  expect_r(1, 'h155, "R8");
    bus_w(2, (1 << 12) | (1 << 8) | 'h10);  expect_r(1, 'h155, "R8");
    bus_w(2, (1 << 12) | (1 << 10) | 'h10); expect_r(1, 'h040, "R8");
    // R7 no auto-increment
    bus_w(2, 'h0400 | 'h20);
    bus_w(1, 'h111); bus_w(1, 'h222);
    expect_r(2, 'h0420, "R7");
    bus_w(2, (1 << 12) | (1 << 10) | 'h20); expect_r(1, 'h222, "R7");
    // R9 read stream with wrap
    bus_w(2, (1 << 12) | (1 << 11) | (1 << 10) | 'hFE);
    expect_r(0, 'h38, "R9");
    expect_r(1, 'h3F8, "R9");
    expect_r(1, 'h3FC, "R9");
    expect_r(1, 0, "R6");
    expect_r(1, 4, "R9");
    expect_r(2, 'h0C03, "R6");
    // R9 priority, request bit reads 0
    bus_w(2, (1 << 12) | 'h0700 | 'h05);
    expect_r(1, 'h14, "R9");
    expect_r(2, 'h0705, "R9");
    // R6 write wrap
    bus_w(2, (1 << 11) | (1 << 8) | 'hFF);
    bus_w(1, 'h2AA); bus_w(1, 'h155);
    expect_r(2, 'h0901, "R6");
    bus_w(2, (1 << 12) | (1 << 11) | (1 << 8) | 'hFF);
    expect_r(1, 'h2AA, "R6");
    expect_r(1, 'h155, "R6");
    // R12 plain address write drops read-ready
    bus_w(2, 'h0400 | 'h30);
    expect_r(0, 'h30, "R12");
    expect_r(1, 0, "R12");
    // R10 plain control bits
    bus_w(0, 'hC6);
    expect_r(0, 'hF6, "R10");
    one_pix('h12, 'h34, 'h56, 'h048, 'h0D0, 'h158, "R10");
    // enable; read-ready cleared, ready flags drop
    bus_w(2, (1 << 12) | (1 << 10));
    bus_w(0, 'h01);
    expect_r(0, 'h01, "R4");
    bus_w(0, 'h39);
    expect_r(0, 'h01, "R4");
    // R3 corrected stream
    pixels(40, 7);
    one_pix('h40, 'h40, 'h40, 'h100, 'h2FF, 'h1C3, "R3");
    one_pix('hFF, 'h00, 'h10, 'h3FC, 'h3FF, 'h155, "R3");
    // R5 writes ignored while enabled
    bus_w(2, 'h0C00 | 'h40);
    bus_w(1, 'h3FF);
    expect_r(2, 'h0400, "R5");
    expect_r(1, 0, "R5");
    one_pix('h40, 'h40, 'h40, 'h100, 'h2FF, 'h1C3, "R5");
    bus_w(0, 'h00);
    expect_r(0, 'h30, "R4");
    bus_w(2, (1 << 12) | (1 << 10) | 'h40); expect_r(1, 'h100, "R5");
    bus_w(2, (1 << 12) | (1 << 10));        expect_r(1, 0, "R5");
    pixels(8, 3);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not finish got 0 exp 1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule